// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts or rotates every element of a 128-bit data vector by an amount of its own. The amount for each element comes from the element at the same position in a second 128-bit vector, so sixteen bytes, eight halfwords or four words can each move by a different distance in one operation. The element size and the operation are chosen per request. The choices are left shift, logical right shift, arithmetic right shift and rotate left.

A request is accepted through a valid/ready handshake on the input side. The result is held in an output register until the consumer takes it. A two-state controller manages the handshake. ST_EMPTY means the output register holds nothing. ST_FULL means it holds a result that has not yet been taken. The transitions are:

- T_LOAD: ST_EMPTY to ST_FULL on an accepted request.
- T_RELOAD: ST_FULL to ST_FULL when the result is taken and a new request is accepted in the same cycle.
- T_DRAIN: ST_FULL to ST_EMPTY when the result is taken and no request arrives.
- T_STALL: ST_FULL to ST_FULL when the result is not taken.

Each lane computes its result in combinational logic. There is no per-bit iteration.

Top module: `vec_lane_shifter`

## Requirements
- R1: `sz_sel` picks the element width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Element k occupies bits [k*W +: W] of `din`, and its amount comes from the same bits of `amt`.
- R2: Only the low log2(W) bits of each amount element are used, so amounts wrap modulo W. An amount of zero returns the element unchanged.
- R3: `op_sel` 0 shifts each element left and fills the vacated low bits with zeros.
- R4: `op_sel` 1 shifts each element right logically and fills the vacated high bits with zeros.
- R5: `op_sel` 2 shifts each element right arithmetically and fills the vacated high bits with the element's top bit.
- R6: `op_sel` 3 rotates each element left, so bits leaving the top of an element re-enter at its bottom.
- R7: A request accepted at a clock edge (`in_vld` and `in_rdy` both high) appears on `dout` with `out_vld` high right after that edge.
- R8: While `out_vld` is high and `out_rdy` is low, `out_vld` stays high and `dout` does not change.
- R9: `in_rdy` is high exactly when the output register is empty or `out_rdy` is high. A request presented while `in_rdy` is low is not taken and does not affect `dout`.
- R10: While `rst_n` is low, `out_vld` is low and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request valid |
| in_rdy | output | 1 | Request can be accepted |
| din | input | 128 | Data vector |
| amt | input | 128 | Per-element shift amounts |
| sz_sel | input | 2 | Element size select |
| op_sel | input | 2 | Operation select |
| out_vld | output | 1 | Result valid |
| out_rdy | input | 1 | Consumer takes the result |
| dout | output | 128 | Registered result |

## Verification
Each result is due exactly one clock edge after the edge at which its request is accepted. `in_rdy` is due in the same cycle as `out_rdy` because it is combinational from it. The bench drives inputs 1 ns after the falling edge. A behavioural model advances on every rising edge from those inputs. Half a nanosecond after the stimulus, `out_vld`, `dout` and `in_rdy` are compared against the model, so every cycle is checked at the point where its registered and combinational values are settled.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
    typedef enum logic [1:0] {
        OP_SHL  = 2'd0,
        OP_SRL  = 2'd1,
        OP_SRA  = 2'd2,
        OP_ROTL = 2'd3
    } shift_op_e;

    typedef enum logic [1:0] {
        SZ_8    = 2'd0,
        SZ_16   = 2'd1,
        SZ_32   = 2'd2,
        SZ_32B  = 2'd3
    } elem_size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;
endpackage

// File: rtl/vshift_elem.sv
module vshift_elem
    import vshift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic [W-1:0] amt,
    input  shift_op_e    op,
    output logic [W-1:0] res
);
    localparam int SW = $clog2(W);

    logic [SW-1:0]  sh;
    logic [2*W-1:0] dbl;
    logic           unused_amt_hi;

    assign sh            = amt[SW-1:0];
    assign unused_amt_hi = ^amt[W-1:SW];
    assign dbl           = {d, d} << sh;

    always_comb begin
        unique case (op)
            OP_SHL:  res = d << sh;
            OP_SRL:  res = d >> sh;
            OP_SRA:  res = $unsigned($signed(d) >>> sh);
            OP_ROTL: res = dbl[2*W-1:W];
            default: res = d;
        endcase
    end

    // R6: rotation keeps the population count of the element
    always_comb begin
        if (op == OP_ROTL) begin
            p_rot_popcount_r6: assert ($countones(res) == $countones(d));
        end
    end

    // R2: a zero amount leaves the element unchanged
    always_comb begin
        if (sh == '0) begin
            p_zero_amt_r2: assert (res == d);
        end
    end

    // R5: arithmetic right shift preserves the sign bit
    always_comb begin
        if (op == OP_SRA) begin
            p_sra_sign_r5: assert (res[W-1] == d[W-1]);
        end
    end
endmodule

// File: rtl/vshift_ctrl.sv
module vshift_ctrl
    import vshift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic out_rdy,
    output logic in_rdy,
    output logic out_vld,
    output logic load
);
    hold_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        in_rdy  = 1'b0;
        out_vld = 1'b0;
        load    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                in_rdy = 1'b1;
                if (in_vld) begin
                    load    = 1'b1;
                    state_d = ST_FULL;      // T_LOAD
                end
            end
            ST_FULL: begin
                out_vld = 1'b1;
                in_rdy  = out_rdy;
                if (out_rdy && in_vld) begin
                    load    = 1'b1;
                    state_d = ST_FULL;      // T_RELOAD
                end else if (out_rdy) begin
                    state_d = ST_EMPTY;     // T_DRAIN
                end else begin
                    state_d = ST_FULL;      // T_STALL
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_rdy) |=> out_vld);

    p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_vld || out_rdy) |-> in_rdy);

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> out_vld);
endmodule

// File: rtl/vec_lane_shifter.sv
module vec_lane_shifter
    import vshift_pkg::*;
#(
    parameter int VEC_W     = 128,
    parameter int ELEM_MIN  = 8,
    parameter int NUM_SIZES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    output logic             in_rdy,
    input  logic [VEC_W-1:0] din,
    input  logic [VEC_W-1:0] amt,
    input  logic [1:0]       sz_sel,
    input  logic [1:0]       op_sel,
    output logic             out_vld,
    input  logic             out_rdy,
    output logic [VEC_W-1:0] dout
);
    shift_op_e    op;
    elem_size_e   sz;
    logic [VEC_W-1:0] res_by_sz [NUM_SIZES];
    logic [VEC_W-1:0] res_sel;
    logic             load;
    logic [VEC_W-1:0] dout_q;

    assign op = shift_op_e'(op_sel);
    assign sz = elem_size_e'(sz_sel);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int W = ELEM_MIN << g;
        localparam int N = VEC_W / W;
        for (genvar e = 0; e < N; e++) begin : g_elem
            vshift_elem #(.W(W)) i_elem (
                .d   (din[e*W +: W]),
                .amt (amt[e*W +: W]),
                .op  (op),
                .res (res_by_sz[g][e*W +: W])
            );
        end
    end

    always_comb begin
        unique case (sz)
            SZ_8:    res_sel = res_by_sz[0];
            SZ_16:   res_sel = res_by_sz[1];
            default: res_sel = res_by_sz[NUM_SIZES-1];
        endcase
    end

    vshift_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .out_rdy (out_rdy),
        .in_rdy  (in_rdy),
        .out_vld (out_vld),
        .load    (load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    dout_q <= '0;
        else if (load) dout_q <= res_sel;
    end

    assign dout = dout_q;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> $stable(dout));

    p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rdy) |=> $stable(dout));
endmodule

// File: tb/test_vec_lane_shifter.sv
`timescale 1ns/100ps
module test_vec_lane_shifter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic         in_rdy;
    logic [127:0] din = '0;
    logic [127:0] amt = '0;
    logic [1:0]   sz_sel = 2'd0;
    logic [1:0]   op_sel = 2'd0;
    logic         out_vld;
    logic         out_rdy = 1'b1;
    logic [127:0] dout;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    bit    done     = 1'b0;
    string tag      = "R10";

    bit           exp_vld = 1'b0;
    logic [127:0] exp_dat = '0;

    always #2 clk = ~clk;

    vec_lane_shifter i_vec_lane_shifter (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
        .din(din), .amt(amt), .sz_sel(sz_sel), .op_sel(op_sel),
        .out_vld(out_vld), .out_rdy(out_rdy), .dout(dout)
    );

    function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] a,
                                           input logic [1:0] s, input logic [1:0] o);
        logic [127:0] r;
        int w;
        w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        r = '0;
        for (int e = 0; e < 128 / w; e++) begin
            int base = e * w;
            int amount = 0;
            for (int k = 0; k < w; k++) if (a[base + k]) amount += (1 << k) % w;
            amount = amount % w;
            for (int b = 0; b < w; b++) begin
                case (o)
                    2'd0: r[base+b] = (b >= amount) ? d[base+b-amount] : 1'b0;
                    2'd1: r[base+b] = (b + amount < w) ? d[base+b+amount] : 1'b0;
                    2'd2: r[base+b] = (b + amount < w) ? d[base+b+amount] : d[base+w-1];
                    default: r[base+b] = d[base + ((b - amount + w) % w)];
                endcase
            end
        end
        return r;
    endfunction

    // reference model advances on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            exp_vld = 1'b0;
            exp_dat = '0;
        end else if (in_vld && (!exp_vld || out_rdy)) begin
            exp_vld = 1'b1;
            exp_dat = model(din, amt, sz_sel, op_sel);
        end else if (out_rdy) begin
            exp_vld = 1'b0;
        end
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // comparison every cycle, after stimulus settles
    always @(negedge clk) begin
        #1.5;
        if (cyc > 0) begin
            n_checks++;
            if (out_vld !== exp_vld || dout !== exp_dat || in_rdy !== (rst_n ? (!exp_vld || out_rdy) : in_rdy)) begin
                n_fail++;
                $display("FAIL %s: actual vld=%0b rdy=%0b dout=%h expected vld=%0b rdy=%0b dout=%h",
                         tag, out_vld, in_rdy, dout, exp_vld, !exp_vld || out_rdy, exp_dat);
            end
        end
    end

    task automatic put(input string t, input logic [127:0] d, input logic [127:0] a,
                       input logic [1:0] s, input logic [1:0] o);
        @(negedge clk); #1;
        tag = t; in_vld = 1'b1; din = d; amt = a; sz_sel = s; op_sel = o;
        @(negedge clk); #1;
        in_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);          // R10 reset state checked by the monitor
        #1 rst_n = 1'b1;
        // R3 left shift, byte lanes, amounts 0..15 (wrap above 7, R2)
        put("R3", {16{8'hB5}}, 128'h0F0E0D0C0B0A09080706050403020100, 2'd0, 2'd0);
        put("R4", {16{8'hB5}}, 128'hF8F9FAFBFCFDFEFF0706050403020100, 2'd0, 2'd1);
        put("R5", {8{16'h8421}}, 128'h0007000F001F00030001000000100011, 2'd1, 2'd2);
        put("R6", {4{32'h80000001}}, 128'h0000001F00000020000000050000003F, 2'd2, 2'd3);
        put("R1", 128'h0123456789ABCDEFFEDCBA9876543210, {4{32'h00000004}}, 2'd3, 2'd0);
        put("R2", 128'hDEADBEEFCAFEF00D0123456789ABCDEF, 128'h20_40_60_80_00_10_30_50_70_90_B0_D0_E0_F0_A0_C0, 2'd0, 2'd2);
        put("R5", {4{32'hF0000000}}, {4{32'h0000001F}}, 2'd2, 2'd2);
        put("R1", 128'h00010002000300040005000600070008, 128'h0001000200030004000500060007000F, 2'd1, 2'd3);
        // R8/R9 backpressure: hold a result while a new request waits
        @(negedge clk); #1;
        out_rdy = 1'b0; tag = "R7";
        in_vld = 1'b1; din = {16{8'h81}}; amt = {16{8'h01}}; sz_sel = 2'd0; op_sel = 2'd3;
        @(negedge clk); #1;
        tag = "R8"; din = {16{8'hFF}}; op_sel = 2'd0;
        repeat (3) @(negedge clk);
        #1 tag = "R9"; in_vld = 1'b1;
        @(negedge clk); #1;
        out_rdy = 1'b1;
        @(negedge clk); #1;
        in_vld = 1'b0;
        repeat (2) @(negedge clk);
        // mixed traffic with toggling consumer
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #1;
            tag = "R7";
            in_vld  = $urandom_range(0, 1);
            out_rdy = ($urandom_range(0, 3) != 0);
            din     = {$urandom, $urandom, $urandom, $urandom};
            amt     = {$urandom, $urandom, $urandom, $urandom};
            sz_sel  = 2'($urandom_range(0, 3));
            op_sel  = 2'($urandom_range(0, 3));
        end
        @(negedge clk); #1 in_vld = 1'b0; out_rdy = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule